// File: doc/BRIEF.md
# Network Controller Interrupt Flag Unit

This block keeps the event flags of a small Ethernet controller and turns them into an interrupt for the host. The transmit and receive engines report three kinds of event as single-cycle pulses: a transmit has ended, a transmit was aborted, and a receive was lost. Each pulse sets a sticky flag. A flag stays set until the host clears it with a bit-field-clear write, or until reset.

An enable register holds one enable bit per flag plus a global enable. The active-low interrupt output gives a pulse one clock long when a flag becomes qualified. A flag is qualified when it is set, its own enable is 1 and the global enable is 1. Disabled flags still set and remain visible on the flag outputs, so the host can poll them.

The host reaches the block through a small command port. Each clock cycle carries one operation code and one data word. The block always drives its flag and enable registers onto outputs, so the host can read them at any time.

Top module: `netc_irq_flags`

## Requirements
- R1: After a synchronous reset, all flags read 0, all enable bits read 0 and `irq_n_o` is 1.
- R2: A 1 on `evt_i[k]` in a cycle makes `flags_o[k]` read 1 from the next cycle on. The bit positions are: 0 = transmit done, 1 = transmit error, 2 = receive error.
- R3: A flag that is 1 stays 1 in every following cycle unless a clear of that bit is issued.
- R4: Operation code 2'b10 is a bit-field clear. Each 1 in `host_wdata_i[2:0]` clears the flag at the same position, and each 0 leaves its flag unchanged. Bit 3 of the data is ignored.
- R5: If an event pulse and a clear of the same bit occur in the same cycle, the flag is 1 afterwards.
- R6: An event on bit 1 (transmit error) also sets flag bit 0 (transmit done) at the same clock edge.
- R7: Operation code 2'b01 loads `host_wdata_i[3:0]` into the enable register, which reads back on `enables_o`. Bits 2:0 are the per-flag enables and bit 3 is the global enable. Codes 2'b00 and 2'b11 change nothing.
- R8: `irq_n_o` goes low only for a flag whose own enable and the global enable are both 1. With either enable at 0, flags still set and read back.
- R9: `irq_n_o` is low for exactly the one cycle that follows a clock edge at which some flag went from unqualified to qualified. A flag that stays qualified does not trigger it again until it has been cleared and set once more.
- R10: Writing enables that qualify a flag which is already set gives one low cycle on `irq_n_o` in the cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 3 | Single-cycle event pulses: bit 0 tx done, bit 1 tx error, bit 2 rx error |
| host_op_i | input | 2 | Host operation: 00 none, 01 write enables, 10 bit-field clear of flags, 11 none |
| host_wdata_i | input | 4 | Host write data |
| flags_o | output | 3 | Current flag register |
| enables_o | output | 4 | Current enable register; bit 3 is the global enable |
| irq_n_o | output | 1 | Active-low interrupt pulse, one clock long |

## Verification
Constrained-random traffic mixes sparse event pulses with random enable writes and random clear masks. It is compared each cycle against a reference model of the flags, the enables and the expected interrupt pulse. The directed cases cover situations the random mix rarely reaches or cannot tell apart. A clear and an event on the same bit in one cycle separates set-wins from clear-wins. A transmit error alone shows whether it also sets the done flag. Polling with the global enable off shows that flags set without any interrupt. Re-raising an event on a flag that is already set shows that a set flag does not fire again. A late enable write shows that the interrupt follows the qualified flag rather than the event pulse.

// File: rtl/netc_irq_pkg.sv
package netc_irq_pkg;
    localparam int NUM_SRC     = 3;
    localparam int EN_W        = NUM_SRC + 1;
    localparam int IDX_TX_DONE = 0;
    localparam int IDX_TX_ERR  = 1;
    localparam int IDX_RX_ERR  = 2;
    localparam int IDX_GIE     = NUM_SRC;

    typedef enum logic [1:0] {
        HOP_NOP   = 2'b00,
        HOP_WR_EN = 2'b01,
        HOP_CLR   = 2'b10,
        HOP_RSVD  = 2'b11
    } host_op_e;

    function automatic logic [NUM_SRC-1:0] qualify(
        input logic [NUM_SRC-1:0] flags,
        input logic [EN_W-1:0]    en
    );
        return en[IDX_GIE] ? (flags & en[NUM_SRC-1:0]) : '0;
    endfunction
endpackage

// File: rtl/netc_flag_bank.sv
module netc_flag_bank #(
    parameter int N   = netc_irq_pkg::NUM_SRC,
    parameter int TXD = netc_irq_pkg::IDX_TX_DONE,
    parameter int TXE = netc_irq_pkg::IDX_TX_ERR
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] flag_d
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic set_bit;
        if (i == TXD) begin : g_linked
            assign set_bit = evt[i] | evt[TXE];
        end else begin : g_plain
            assign set_bit = evt[i];
        end
        // set has priority over a clear of the same bit
        assign flag_d[i] = set_bit | (flag_q[i] & ~clr_mask[i]);
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= flag_d[i];
        end
    end
endmodule

// File: rtl/netc_enable_reg.sv
module netc_enable_reg #(
    parameter int W = netc_irq_pkg::EN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] en_d
);
    assign en_d = wr ? wdata : en_q;
    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end
endmodule

// File: rtl/netc_irq_pulse.sv
module netc_irq_pulse #(
    parameter int N = netc_irq_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] qual_q,
    input  logic [N-1:0] qual_d,
    output logic         irq_n
);
    logic rise;
    assign rise = |(qual_d & ~qual_q);
    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= ~rise;
    end
endmodule

// File: rtl/netc_irq_flags.sv
module netc_irq_flags
    import netc_irq_pkg::*;
#(
    parameter int NSRC = netc_irq_pkg::NUM_SRC,
    parameter int ENW  = NSRC + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_i,
    input  logic [1:0]      host_op_i,
    input  logic [ENW-1:0]  host_wdata_i,
    output logic [NSRC-1:0] flags_o,
    output logic [ENW-1:0]  enables_o,
    output logic            irq_n_o
);
    host_op_e        op;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] flag_d;
    logic [ENW-1:0]  en_d;
    logic [NSRC-1:0] qual_q;
    logic [NSRC-1:0] qual_d;

    assign op       = host_op_e'(host_op_i);
    assign clr_mask = (op == HOP_CLR) ? host_wdata_i[NSRC-1:0] : '0;

    netc_flag_bank #(.N(NSRC), .TXD(IDX_TX_DONE), .TXE(IDX_TX_ERR)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_i),
        .clr_mask (clr_mask),
        .flag_q   (flags_o),
        .flag_d   (flag_d)
    );

    netc_enable_reg #(.W(ENW)) u_enables (
        .clk   (clk),
        .rst   (rst),
        .wr    (op == HOP_WR_EN),
        .wdata (host_wdata_i),
        .en_q  (enables_o),
        .en_d  (en_d)
    );

    assign qual_q = qualify(flags_o, enables_o);
    assign qual_d = qualify(flag_d, en_d);

    netc_irq_pulse #(.N(NSRC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .qual_q (qual_q),
        .qual_d (qual_d),
        .irq_n  (irq_n_o)
    );
endmodule

// File: rtl/netc_irq_checker.sv
module netc_irq_checker
    import netc_irq_pkg::*;
#(
    parameter int NSRC = netc_irq_pkg::NUM_SRC,
    parameter int ENW  = NSRC + 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] evt_i,
    input logic [1:0]      host_op_i,
    input logic [ENW-1:0]  host_wdata_i,
    input logic [NSRC-1:0] flags_o,
    input logic [ENW-1:0]  enables_o,
    input logic            irq_n_o
);
    logic [NSRC-1:0] clr_req;
    logic [NSRC-1:0] set_req;
    logic [NSRC-1:0] qual_now;

    assign clr_req  = (host_op_i == 2'b10) ? host_wdata_i[NSRC-1:0] : '0;
    assign set_req  = evt_i | (evt_i[IDX_TX_ERR] ? (NSRC'(1) << IDX_TX_DONE) : '0);
    assign qual_now = enables_o[NSRC] ? (flags_o & enables_o[NSRC-1:0]) : '0;

    // R3: a set flag survives unless its bit was cleared
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (($past(flags_o) & ~$past(clr_req)) & ~flags_o) == '0);

    // R2: an event always leaves its flag set; R5: also when a clear collides
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(set_req) & ~flags_o) == '0);

    // R6: transmit error drags transmit done along
    assert_txerr_sets_done_R6: assert property (@(posedge clk) disable iff (rst)
        evt_i[IDX_TX_ERR] |=> flags_o[IDX_TX_DONE]);

    // R2: a flag rises only after an event on it
    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (rst)
        ((flags_o & ~$past(flags_o)) & ~$past(set_req)) == '0);

    // R9: low output exactly after a qualified flag rose
    assert_irq_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_o) == ((qual_now & ~$past(qual_now)) != '0));

    // R8: no interrupt while the global enable is off
    assert_gated_by_global_R8: assert property (@(posedge clk) disable iff (rst)
        !enables_o[NSRC] |-> irq_n_o);

    // R7: enables move only on an enable write
    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(host_op_i) != 2'b01) |-> $stable(enables_o));
endmodule

bind netc_irq_flags netc_irq_checker #(.NSRC(NSRC), .ENW(ENW)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (evt_i),
    .host_op_i    (host_op_i),
    .host_wdata_i (host_wdata_i),
    .flags_o      (flags_o),
    .enables_o    (enables_o),
    .irq_n_o      (irq_n_o)
);

// File: tb/test_netc_irq_flags.sv
module test_netc_irq_flags;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] evt_i = '0;
    logic [1:0] host_op_i = '0;
    logic [3:0] host_wdata_i = '0;
    logic [2:0] flags_o;
    logic [3:0] enables_o;
    logic       irq_n_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] m_flags = '0;
    logic [3:0] m_en = '0;
    logic       m_irq_n = 1'b1;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    netc_irq_flags i_netc_irq_flags (
        .clk(clk), .rst(rst), .evt_i(evt_i), .host_op_i(host_op_i),
        .host_wdata_i(host_wdata_i), .flags_o(flags_o),
        .enables_o(enables_o), .irq_n_o(irq_n_o)
    );

    function automatic logic [2:0] f_qual(logic [2:0] f, logic [3:0] e);
        return e[3] ? (f & e[2:0]) : 3'b000;
    endfunction

    function automatic logic [2:0] f_next_flags(logic [2:0] f, logic [2:0] ev,
                                                logic [1:0] op, logic [3:0] wd);
        logic [2:0] s;
        logic [2:0] c;
        s = ev | {2'b00, ev[1]};
        c = (op == 2'b10) ? wd[2:0] : 3'b000;
        return s | (f & ~c);
    endfunction

    function automatic logic [3:0] f_next_en(logic [3:0] e, logic [1:0] op, logic [3:0] wd);
        return (op == 2'b01) ? wd : e;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, update model at edge, compare at next negedge
    task automatic step(logic [2:0] ev, logic [1:0] op, logic [3:0] wd, string req);
        logic [2:0] nf;
        logic [3:0] ne;
        evt_i = ev; host_op_i = op; host_wdata_i = wd;
        @(posedge clk);
        nf = f_next_flags(m_flags, ev, op, wd);
        ne = f_next_en(m_en, op, wd);
        m_irq_n = ~|(f_qual(nf, ne) & ~f_qual(m_flags, m_en));
        m_flags = nf;
        m_en = ne;
        @(negedge clk);
        evt_i = '0; host_op_i = '0; host_wdata_i = '0;
        check({req, " flags"}, 32'(flags_o), 32'(m_flags));
        check({req, " enables"}, 32'(enables_o), 32'(m_en));
        check({req, " irq_n"}, 32'(irq_n_o), 32'(m_irq_n));
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1c0d));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 flags", 32'(flags_o), 0);
        check("R1 enables", 32'(enables_o), 0);
        check("R1 irq_n", 32'(irq_n_o), 1);

        // R8: polling with interrupts disabled
        step(3'b100, 2'b00, 4'h0, "R8 poll");
        check("R2 rx err flag", 32'(flags_o), 32'h4);
        check("R8 no irq", 32'(irq_n_o), 1);
        // R3: flag holds over idle cycles
        step(3'b000, 2'b00, 4'h0, "R3 hold");
        step(3'b000, 2'b11, 4'hF, "R7 reserved op");
        check("R3 sticky", 32'(flags_o), 32'h4);
        // R10: late enable of already-set flag
        step(3'b000, 2'b01, 4'hC, "R10 late enable");
        check("R10 pulse", 32'(irq_n_o), 0);
        step(3'b000, 2'b00, 4'h0, "R9 single");
        check("R9 one cycle", 32'(irq_n_o), 1);
        // R9: re-raising set flag does not re-fire
        step(3'b100, 2'b00, 4'h0, "R9 no retrigger");
        check("R9 no retrigger", 32'(irq_n_o), 1);
        // R4: partial clear; bit 3 of data ignored
        step(3'b011, 2'b00, 4'h0, "R6 setup");
        step(3'b000, 2'b10, 4'hA, "R4 partial clear");
        check("R4 partial clear", 32'(flags_o), 32'h5);
        // R5: set wins over same-bit clear
        step(3'b100, 2'b10, 4'h4, "R5 collide");
        check("R5 set wins", 32'(flags_o), 32'h5);
        step(3'b000, 2'b10, 4'h7, "R4 clear all");
        check("R4 cleared", 32'(flags_o), 0);
        // R6: tx error also sets tx done, with pulse for enabled done
        step(3'b000, 2'b01, 4'h9, "R7 enable done only");
        check("R7 readback", 32'(enables_o), 32'h9);
        step(3'b010, 2'b00, 4'h0, "R6 tx err");
        check("R6 both flags", 32'(flags_o), 32'h3);
        check("R6 irq via done", 32'(irq_n_o), 0);
        // R8: global enable off masks new flag
        step(3'b000, 2'b10, 4'h7, "R4 clr");
        step(3'b000, 2'b01, 4'h7, "R8 global off");
        step(3'b001, 2'b00, 4'h0, "R8 masked");
        check("R8 masked irq", 32'(irq_n_o), 1);
        check("R8 flag visible", 32'(flags_o), 32'h1);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] ev;
            logic [1:0] op;
            ev[0] = ($urandom % 6) == 0;
            ev[1] = ($urandom % 9) == 0;
            ev[2] = ($urandom % 7) == 0;
            op = 2'($urandom % 4);
            step(ev, op, 4'($urandom), "R2 R3 R4 R9 random");
        end

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_flags = '0; m_en = '0;
        check("R1 re-reset flags", 32'(flags_o), 0);
        check("R1 re-reset irq_n", 32'(irq_n_o), 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule